// File: doc/BRIEF.md
# MIDI Host Port, UART Pass-Through Mode

This block sits between a host byte bus and a serial MIDI core. The host sees two byte-wide registers at adjacent addresses: a data register (address 0) and a shared command/status register (address 1). Writing the command address issues a command; reading it returns two active-low flags, one telling the host that a byte is waiting to be read and one telling it that the data register is busy with an earlier byte.

Only two command bytes are understood. 0x3F places the port in UART pass-through mode, where every data byte the host writes goes to the serial transmitter and every byte the serial receiver delivers is held for the host. 0xFF returns the port to its idle, non-UART state and flushes both one-byte holding registers. Each recognised command queues the acknowledge byte 0xFE, which the host collects by reading the data register. The serial side uses byte valid/ready handshakes, and the port emits single-cycle event pulses for an interrupt unit when the transmit holding register empties and when a received byte lands.

Top module: `midi_uart_port`

## Requirements
- R1: After reset, status reads 0x80, the port is out of UART mode, `rx_ready` and `tx_valid` are low and both event pulses are low.
- R2: Status bit 7 is 0 exactly when a byte waits in the receive holding register, bit 6 is 1 exactly when the transmit holding register is occupied, and bits 5..0 read 0.
- R3: Writing 0x3F to address 1 enters UART mode and queues the acknowledge byte 0xFE.
- R4: Writing 0xFF to address 1 flushes the transmit holding register, leaves UART mode and leaves 0xFE as the only byte waiting for the host.
- R5: Any other command byte changes neither the mode nor either holding register.
- R6: A read of address 0 returns the waiting byte and sets status bit 7 back to 1 on the following cycle; a read with nothing waiting changes nothing.
- R7: In UART mode a data write with the transmit register empty puts the byte on `tx_byte` with `tx_valid` high, held stable until `tx_ready` is seen.
- R8: A data write while the transmit register is occupied, or while out of UART mode, is discarded.
- R9: The cycle after a transmit handshake, `tx_empty_evt` is high for exactly one cycle and status bit 6 is 0.
- R10: `rx_ready` is high only in UART mode with the receive register empty; an accepted byte is readable from the next cycle, when `rx_evt` pulses for one cycle.
- R11: An acknowledge replaces any received byte still waiting, and `rx_ready` is low during a cycle that writes a recognised command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | 0 = data register, 1 = command/status |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte for the addressed register |
| tx_byte | output | 8 | Byte offered to the serial transmitter |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Serial transmitter accepts the byte |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Port can take a received byte |
| tx_empty_evt | output | 1 | One-cycle pulse after the transmit byte is handed off |
| rx_evt | output | 1 | One-cycle pulse after a received byte lands |

## Verification
The assertions assume the host never raises `host_wr` and `host_rd` in the same cycle and that the serial receiver holds `rx_byte` steady while `rx_valid` is high. They also assume a reset is applied before any strobe, since the handshake checks look one cycle back. The stimulus drives one host access at a time through tasks that raise a strobe for a single cycle, and it only changes `rx_valid`, `rx_byte` and `tx_ready` just after a clock edge, so each handshake is seen on exactly one edge.

// File: rtl/midi_port_pkg.sv
package midi_port_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_RESET = 8'hFF;
  localparam logic [BYTE_W-1:0] CMD_UART  = 8'h3F;
  localparam logic [BYTE_W-1:0] ACK_BYTE  = 8'hFE;

  typedef enum logic [1:0] {
    CK_NONE  = 2'd0,
    CK_RESET = 2'd1,
    CK_UART  = 2'd2
  } cmd_kind_e;

  function automatic cmd_kind_e classify_cmd(input logic [BYTE_W-1:0] b);
    if (b == CMD_RESET)     return CK_RESET;
    else if (b == CMD_UART) return CK_UART;
    else                    return CK_NONE;
  endfunction

  // bit 7: 0 = byte waiting; bit 6: 1 = transmit register busy
  function automatic logic [BYTE_W-1:0] pack_status(input logic rx_full, input logic tx_full);
    return {~rx_full, tx_full, {(BYTE_W-2){1'b0}}};
  endfunction
endpackage

// File: rtl/midi_cmd_decode.sv
module midi_cmd_decode
  import midi_port_pkg::*;
(
  input  logic              cmd_wr,
  input  logic [BYTE_W-1:0] cmd_byte,
  output cmd_kind_e         kind,
  output logic              ack_now,
  output logic              flush_now,
  output logic              enter_now
);
  always_comb begin
    kind      = cmd_wr ? classify_cmd(cmd_byte) : CK_NONE;
    flush_now = (kind == CK_RESET);
    enter_now = (kind == CK_UART);
    ack_now   = flush_now | enter_now;
  end
endmodule

// File: rtl/midi_hold_reg.sv
module midi_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ldata,
  input  logic         take,
  input  logic         flush,
  output logic         full,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      q    <= '0;
    end else if (load) begin
      full <= 1'b1;
      q    <= ldata;
    end else if (take || flush) begin
      full <= 1'b0;
    end
  end

  // R7
  hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (full && q == $past(ldata)));

  // R6
  hold_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !full);
endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port
  import midi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              tx_empty_evt,
  output logic              rx_evt
);
  logic      uart_mode;
  cmd_kind_e cmd_kind;
  logic      ack_now, flush_now, enter_now;
  logic      cmd_wr, data_wr, data_rd;
  logic      tx_full, rx_full;
  logic [BYTE_W-1:0] tx_q, rx_q;
  logic      tx_load, tx_hand, rx_accept, rx_load;
  logic [BYTE_W-1:0] rx_ldata;
  logic      tx_evt_q, rx_evt_q;

  assign cmd_wr  = host_wr &&  host_addr;
  assign data_wr = host_wr && !host_addr;
  assign data_rd = host_rd && !host_addr;

  midi_cmd_decode u_dec (
    .cmd_wr   (cmd_wr),
    .cmd_byte (host_wdata),
    .kind     (cmd_kind),
    .ack_now  (ack_now),
    .flush_now(flush_now),
    .enter_now(enter_now)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         uart_mode <= 1'b0;
    else if (flush_now) uart_mode <= 1'b0;
    else if (enter_now) uart_mode <= 1'b1;
  end

  // transmit side
  assign tx_load  = data_wr && uart_mode && !tx_full;
  assign tx_hand  = tx_full && tx_ready;
  assign tx_valid = tx_full;
  assign tx_byte  = tx_q;

  midi_hold_reg #(.W(BYTE_W)) u_txh (
    .clk(clk), .rst_n(rst_n),
    .load(tx_load), .ldata(host_wdata),
    .take(tx_hand), .flush(flush_now),
    .full(tx_full), .q(tx_q)
  );

  // receive side: an acknowledge takes priority over serial data
  assign rx_ready  = uart_mode && !rx_full && !ack_now;
  assign rx_accept = rx_valid && rx_ready;
  assign rx_load   = ack_now || rx_accept;
  assign rx_ldata  = ack_now ? ACK_BYTE : rx_byte;

  midi_hold_reg #(.W(BYTE_W)) u_rxh (
    .clk(clk), .rst_n(rst_n),
    .load(rx_load), .ldata(rx_ldata),
    .take(data_rd), .flush(flush_now),
    .full(rx_full), .q(rx_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_evt_q <= 1'b0;
      rx_evt_q <= 1'b0;
    end else begin
      tx_evt_q <= tx_hand && !flush_now;
      rx_evt_q <= rx_accept;
    end
  end

  assign tx_empty_evt = tx_evt_q;
  assign rx_evt       = rx_evt_q;
  assign host_rdata   = host_addr ? pack_status(rx_full, tx_full) : rx_q;

  // R7
  tx_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flush_now) |=> (tx_valid && $stable(tx_byte)));

  // R8
  no_tx_outside_uart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uart_mode |-> !tx_valid);

  // R9
  tx_evt_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_evt |-> (!tx_valid && host_rdata[6] == 1'b0 || host_addr == 1'b0 && !tx_valid));

  // R9
  tx_evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_evt |=> !tx_empty_evt);

  // R3
  ack_queued_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_now |=> (rx_full && rx_q == ACK_BYTE));

  // R4
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_now |=> (!uart_mode && !tx_valid && !rx_ready));

  // R5
  other_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_kind == CK_NONE) |=> $stable(uart_mode));

  // R10
  rx_evt_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |-> rx_full);

  // R11
  rx_block_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_now |-> !rx_ready);
endmodule

// File: tb/midi_uart_port_tb.sv
module midi_uart_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [7:0] tx_byte;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic       tx_empty_evt, rx_evt;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_rx[$];
  logic [7:0] exp_tx[$];

  always #5 clk = ~clk;

  midi_uart_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_empty_evt(tx_empty_evt), .rx_evt(rx_evt)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // transmit monitor: pops the scoreboard on each handshake
  always @(negedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      if (exp_tx.size() == 0) check("R8 unexpected tx byte", tx_byte, 8'hxx);
      else check("R7 tx byte", tx_byte, exp_tx.pop_front());
    end
  end

  task automatic host_write(input logic a, input logic [7:0] b);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = b;
    @(posedge clk); #1;
    host_wr = 1'b0; host_addr = 1'b0;
  endtask

  task automatic read_data(input string req);
    @(posedge clk); #1;
    host_rd = 1'b1; host_addr = 1'b0;
    @(negedge clk);
    if (exp_rx.size() == 0) check(req, host_rdata, 8'hxx);
    else check(req, host_rdata, exp_rx.pop_front());
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  task automatic check_status(input string req, input logic [7:0] exp);
    @(negedge clk);
    host_addr = 1'b1;
    #1 check(req, host_rdata, exp);
    host_addr = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_byte = b;
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check_status("R1 status", 8'h80);
    check("R1 tx_valid", {7'd0, tx_valid}, 8'h00);
    check("R1 rx_ready", {7'd0, rx_ready}, 8'h00);
    check("R1 events", {6'd0, tx_empty_evt, rx_evt}, 8'h00);

    // R8 data write outside UART mode is dropped
    host_write(1'b0, 8'h55);
    @(negedge clk);
    check("R8 no tx outside mode", {7'd0, tx_valid}, 8'h00);

    // R5 unknown command ignored
    host_write(1'b1, 8'h12);
    check_status("R5 status after unknown cmd", 8'h80);
    check("R5 mode unchanged", {7'd0, rx_ready}, 8'h00);

    // R3 enter UART mode, acknowledge queued
    host_write(1'b1, 8'h3F);
    check_status("R3 ack waiting", 8'h00);
    exp_rx.push_back(8'hFE);
    read_data("R3 ack byte");
    check_status("R6 bit7 after read", 8'h80);
    host_rd = 1'b0;
    @(posedge clk); #1 host_rd = 1'b1;
    @(posedge clk); #1 host_rd = 1'b0;
    check_status("R6 empty read no change", 8'h80);
    check("R10 rx_ready in mode", {7'd0, rx_ready}, 8'h01);

    // R7 / R8 / R9 transmit path
    tx_ready = 1'b0;
    host_write(1'b0, 8'h90);
    exp_tx.push_back(8'h90);
    check_status("R2 tx busy", 8'hC0);
    check("R7 tx_valid", {7'd0, tx_valid}, 8'h01);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 tx byte held", tx_byte, 8'h90);
    host_write(1'b0, 8'h91);
    @(negedge clk);
    check("R8 write while full dropped", tx_byte, 8'h90);
    @(posedge clk); #1 tx_ready = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check("R9 tx_empty_evt high", {7'd0, tx_empty_evt}, 8'h01);
    host_addr = 1'b1; #1;
    check("R9 bit6 cleared", host_rdata, 8'h80);
    host_addr = 1'b0;
    @(negedge clk);
    check("R9 tx_empty_evt one cycle", {7'd0, tx_empty_evt}, 8'h00);
    tx_ready = 1'b0;

    // R10 receive path
    send_rx(8'h3C);
    exp_rx.push_back(8'h3C);
    @(negedge clk);
    check("R10 rx_evt", {7'd0, rx_evt}, 8'h01);
    check("R10 rx_ready low when full", {7'd0, rx_ready}, 8'h00);
    check_status("R2 rx waiting", 8'h00);
    check("R10 rx_evt one cycle", {7'd0, rx_evt}, 8'h00);
    read_data("R10 rx byte");

    // R11 ack replaces pending byte; rx_ready blocked during command
    send_rx(8'h44);
    host_write(1'b1, 8'h3F);
    exp_rx.push_back(8'hFE);
    read_data("R11 ack overwrites");
    check_status("R11 nothing left", 8'h80);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = 1'b1; host_wdata = 8'h3F;
    @(negedge clk);
    check("R11 rx_ready low on cmd", {7'd0, rx_ready}, 8'h00);
    @(posedge clk); #1 host_wr = 1'b0; host_addr = 1'b0;
    exp_rx.push_back(8'hFE);
    read_data("R11 second ack");

    // R5 unknown command inside UART mode
    host_write(1'b1, 8'hAA);
    check("R5 mode kept", {7'd0, rx_ready}, 8'h01);
    check_status("R5 no ack", 8'h80);

    // R4 reset command
    host_write(1'b0, 8'h77);
    send_rx(8'h22);
    host_write(1'b1, 8'hFF);
    check("R4 tx flushed", {7'd0, tx_valid}, 8'h00);
    check_status("R4 status", 8'h00);
    exp_rx.push_back(8'hFE);
    read_data("R4 ack byte");
    check("R4 mode left", {7'd0, rx_ready}, 8'h00);
    check_status("R4 nothing else waiting", 8'h80);
    host_write(1'b0, 8'h66);
    @(negedge clk);
    check("R8 write after reset dropped", {7'd0, tx_valid}, 8'h00);
    repeat (3) @(posedge clk);

    check("R7 tx scoreboard drained", exp_tx.size(), 8'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule